// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block turns a simple synchronous request port into the strobe sequences of an asynchronous DRAM of 65536 words by 4 bits. The address pins are multiplexed. Each host request carries a 16-bit word address, 4 bits of write data and a direction flag. A request is accepted on a valid/ready handshake. The controller sends the upper address byte as the row and the lower byte as the column over an 8-bit pin bus. It drives the row strobe, column strobe, write strobe and output enable, and it decides when its own data drivers are on. A read ends with a one-cycle response pulse that carries the stored nibble.

After each access the controller leaves the row open. A later request to the same row then only needs a column-strobe pulse. A request to any other row first precharges the array and then opens the new row. A refresh timer raises a request at a fixed clock interval. The sequencer serves it between host transactions with a cycle that pulses only the row strobe, taking the row from a wrapping 8-bit counter. Every strobe width and every setup or precharge time is a clock-cycle count set by a parameter.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: At each row-strobe fall the pin bus carries req_addr[15:8]. At each column-strobe fall it carries req_addr[7:0] of the request being served.
- R2: The pin bus holds the same value in the clock before the row strobe falls and in the cycle in which it falls. The column address is not presented until the row strobe has been low for T_RAH cycles.
- R3: The write strobe is high at the column-strobe fall of a read. For a write it is already low one cycle before the column strobe falls, and the write data and column address are on the pins in both cycles.
- R4: The controller drives the data pins only while the write strobe is low, which gives exactly 1 + T_CAS cycles per write and none during a read. Output enable is low only while the column strobe is low in a read.
- R5: A request to the row that is open causes no row-strobe transition. It is served with a single column-strobe pulse.
- R6: Before the row strobe falls again, it has been high for at least T_RP cycles. A request to a different row therefore opens its row only after a precharge.
- R7: The column strobe is low only while the row strobe is low.
- R8: Every REF_INTERVAL clocks a refresh cycle is run. The row strobe pulses while the column strobe stays high. The row on the pins comes from an 8-bit counter that increases by one, modulo 256, for each refresh.
- R9: A pending refresh is served only between transactions. While it is pending, req_ready is low. A refresh closes any open row, so the next access reopens its row.
- R10: Each read gives exactly one rsp_valid pulse, one cycle long, carrying the nibble last written to that address. A write gives none.
- R11: During reset all strobes are high, the data drivers are off and rsp_valid is low. After reset req_ready is high.
- R12: Each column-strobe pulse is low for exactly T_CAS clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address, row in upper byte |
| req_wdata | input | 4 | Write nibble |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 4 | Read nibble |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Device output enable, active low |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data toward the device |
| dram_dq_oe | output | 1 | Enable of the controller's data drivers |
| dram_dq_in | input | 4 | Data from the device |

## Verification
A sequencer that wrongly believes a row is open shows up at the next request as a column strobe with no row-strobe fall before it. The data then read back belongs to the previous row, and the mismatch appears in that same read response. A sequencer that wrongly believes the row is closed shows up as an extra row-strobe fall, which the activation count in that transaction catches. A corrupted timing counter shows up within one pulse as a wrong strobe width or a short precharge. A stuck or skipped refresh row counter shows up on the next refresh as a row address that is not one more than the last.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_OPEN,
      S_ROWSET,
      S_RASH,
      S_COLSET,
      S_CAS,
      S_CASP,
      S_PRE,
      S_REFSET,
      S_REFRAS
   } fpm_state_e;

   function automatic int fpm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
   parameter int unsigned INTERVAL = 1560,
   parameter bit          ENABLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pending
);

   generate
      if (ENABLE) begin : g_on
         localparam int W = $clog2(INTERVAL);
         localparam logic [W-1:0] LAST = W'(INTERVAL - 1);
         logic [W-1:0] tick_cnt_q;
         logic         pend_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tick_cnt_q <= '0;
               pend_q     <= 1'b0;
            end else begin
               if (tick_cnt_q == LAST) tick_cnt_q <= '0;
               else                    tick_cnt_q <= tick_cnt_q + 1'b1;
               if (tick_cnt_q == LAST) pend_q <= 1'b1;
               else if (ack)           pend_q <= 1'b0;
            end
         end
         assign pending = pend_q;
      end else begin : g_off
         logic unused_ack;
         assign unused_ack = ack;
         assign pending    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fpm_pin_decode.sv
module fpm_pin_decode
   import fpm_pkg::*;
#(
   parameter int MUX_W  = 8,
   parameter int DATA_W = 4
) (
   input  fpm_state_e        state,
   input  logic [MUX_W-1:0]  row,
   input  logic [MUX_W-1:0]  col,
   input  logic [MUX_W-1:0]  ref_row,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [MUX_W-1:0]  addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   logic col_phase;
   logic wr_window;

   always_comb begin
      ras_n     = !(state inside {S_RASH, S_COLSET, S_CAS, S_CASP, S_OPEN, S_REFRAS});
      cas_n     = (state != S_CAS);
      col_phase = state inside {S_COLSET, S_CAS, S_CASP, S_OPEN};
      wr_window = we && (state inside {S_COLSET, S_CAS});
      we_n      = !wr_window;
      dq_oe     = wr_window;
      oe_n      = !(!we && state == S_CAS);
      dq_out    = wdata;
      if (state inside {S_REFSET, S_REFRAS}) addr = ref_row;
      else if (col_phase)                    addr = col;
      else                                   addr = row;
   end

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
   import fpm_pkg::*;
#(
   parameter int MUX_W  = 8,
   parameter int DATA_W = 4,
   parameter int T_RP   = 3,
   parameter int T_RAH  = 2,
   parameter int T_CAS  = 2,
   parameter int T_CP   = 1,
   parameter int T_REF  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_we,
   input  logic [2*MUX_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                req_ready,
   input  logic                ref_pending,
   output logic                ref_ack,
   input  logic [DATA_W-1:0]   dq_in,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_data,
   output fpm_state_e          state_o,
   output logic [MUX_W-1:0]    row_o,
   output logic [MUX_W-1:0]    col_o,
   output logic [MUX_W-1:0]    ref_row_o,
   output logic                we_o,
   output logic [DATA_W-1:0]   wdata_o
);

   localparam int T_MAX = fpm_max(fpm_max(fpm_max(T_RP, T_RAH), fpm_max(T_CAS, T_CP)), T_REF);
   localparam int CNT_W = $clog2(T_MAX + 1);
   localparam logic [CNT_W-1:0] C_RP  = CNT_W'(T_RP);
   localparam logic [CNT_W-1:0] C_RAH = CNT_W'(T_RAH);
   localparam logic [CNT_W-1:0] C_CAS = CNT_W'(T_CAS);
   localparam logic [CNT_W-1:0] C_CP  = CNT_W'(T_CP);
   localparam logic [CNT_W-1:0] C_REF = CNT_W'(T_REF);

   fpm_state_e         state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [MUX_W-1:0]   row_q, col_q, open_row_q, ref_row_q;
   logic               we_q, reopen_q, rsp_valid_q;
   logic [DATA_W-1:0]  wd_q, rsp_data_q;
   logic               last, take;
   logic [MUX_W-1:0]   req_row;

   assign last      = (cnt_q == CNT_W'(1));
   assign req_row   = req_addr[2*MUX_W-1:MUX_W];
   assign req_ready = (state_q inside {S_IDLE, S_OPEN}) && !ref_pending;
   assign take      = req_valid && req_ready;
   assign ref_ack   = (state_q == S_REFRAS) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         cnt_q       <= '0;
         row_q       <= '0;
         col_q       <= '0;
         open_row_q  <= '0;
         ref_row_q   <= '0;
         we_q        <= 1'b0;
         wd_q        <= '0;
         reopen_q    <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         if (take) begin
            row_q <= req_row;
            col_q <= req_addr[MUX_W-1:0];
            we_q  <= req_we;
            wd_q  <= req_wdata;
         end
         case (state_q)
            S_IDLE: begin
               if (ref_pending) state_q <= S_REFSET;
               else if (take)   state_q <= S_ROWSET;
            end
            S_OPEN: begin
               if (ref_pending) begin
                  state_q  <= S_PRE;
                  cnt_q    <= C_RP;
                  reopen_q <= 1'b0;
               end else if (take) begin
                  if (req_row == open_row_q) begin
                     state_q <= S_COLSET;
                  end else begin
                     state_q  <= S_PRE;
                     cnt_q    <= C_RP;
                     reopen_q <= 1'b1;
                  end
               end
            end
            S_ROWSET: begin
               state_q <= S_RASH;
               cnt_q   <= C_RAH;
            end
            S_RASH: begin
               if (last) begin
                  state_q    <= S_COLSET;
                  open_row_q <= row_q;
               end else cnt_q <= cnt_q - 1'b1;
            end
            S_COLSET: begin
               state_q <= S_CAS;
               cnt_q   <= C_CAS;
            end
            S_CAS: begin
               if (last) begin
                  state_q <= S_CASP;
                  cnt_q   <= C_CP;
                  if (!we_q) begin
                     rsp_valid_q <= 1'b1;
                     rsp_data_q  <= dq_in;
                  end
               end else cnt_q <= cnt_q - 1'b1;
            end
            S_CASP: begin
               if (last) state_q <= S_OPEN;
               else      cnt_q   <= cnt_q - 1'b1;
            end
            S_PRE: begin
               if (last) state_q <= reopen_q ? S_ROWSET : S_IDLE;
               else      cnt_q   <= cnt_q - 1'b1;
            end
            S_REFSET: begin
               state_q <= S_REFRAS;
               cnt_q   <= C_REF;
            end
            S_REFRAS: begin
               if (last) begin
                  state_q   <= S_PRE;
                  cnt_q     <= C_RP;
                  reopen_q  <= 1'b0;
                  ref_row_q <= ref_row_q + 1'b1;
               end else cnt_q <= cnt_q - 1'b1;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;
   assign state_o   = state_q;
   assign row_o     = row_q;
   assign col_o     = col_q;
   assign ref_row_o = ref_row_q;
   assign we_o      = we_q;
   assign wdata_o   = wd_q;

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
   import fpm_pkg::*;
#(
   parameter int          MUX_W        = 8,
   parameter int          DATA_W       = 4,
   parameter int          T_RP         = 3,
   parameter int          T_RAH        = 2,
   parameter int          T_CAS        = 2,
   parameter int          T_CP         = 1,
   parameter int          T_REF        = 4,
   parameter int unsigned REF_INTERVAL = 1560,
   parameter bit          REF_EN       = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_we,
   input  logic [2*MUX_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                dram_ras_n,
   output logic                dram_cas_n,
   output logic                dram_we_n,
   output logic                dram_oe_n,
   output logic [MUX_W-1:0]    dram_addr,
   output logic [DATA_W-1:0]   dram_dq_out,
   output logic                dram_dq_oe,
   input  logic [DATA_W-1:0]   dram_dq_in
);

   generate
      if (T_RP < 1 || T_RAH < 1 || T_CAS < 1 || T_CP < 1 || T_REF < 1) begin : g_bad_timing
         $error("fpm_dram_ctrl: every timing count must be at least one cycle");
      end
      if (REF_EN && REF_INTERVAL < 2) begin : g_bad_interval
         $error("fpm_dram_ctrl: refresh interval must be at least two cycles");
      end
      if (MUX_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("fpm_dram_ctrl: widths must be positive");
      end
   endgenerate

   fpm_state_e        st;
   logic [MUX_W-1:0]  row, col, ref_row;
   logic              we;
   logic [DATA_W-1:0] wdata;
   logic              ref_pending, ref_ack;

   fpm_refresh_timer #(
      .INTERVAL (REF_INTERVAL),
      .ENABLE   (REF_EN)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack     (ref_ack),
      .pending (ref_pending)
   );

   fpm_seq #(
      .MUX_W  (MUX_W),
      .DATA_W (DATA_W),
      .T_RP   (T_RP),
      .T_RAH  (T_RAH),
      .T_CAS  (T_CAS),
      .T_CP   (T_CP),
      .T_REF  (T_REF)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_we      (req_we),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .req_ready   (req_ready),
      .ref_pending (ref_pending),
      .ref_ack     (ref_ack),
      .dq_in       (dram_dq_in),
      .rsp_valid   (rsp_valid),
      .rsp_data    (rsp_rdata),
      .state_o     (st),
      .row_o       (row),
      .col_o       (col),
      .ref_row_o   (ref_row),
      .we_o        (we),
      .wdata_o     (wdata)
   );

   fpm_pin_decode #(
      .MUX_W  (MUX_W),
      .DATA_W (DATA_W)
   ) i_pins (
      .state   (st),
      .row     (row),
      .col     (col),
      .ref_row (ref_row),
      .we      (we),
      .wdata   (wdata),
      .ras_n   (dram_ras_n),
      .cas_n   (dram_cas_n),
      .we_n    (dram_we_n),
      .oe_n    (dram_oe_n),
      .addr    (dram_addr),
      .dq_out  (dram_dq_out),
      .dq_oe   (dram_dq_oe)
   );

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
   parameter int MUX_W = 8,
   parameter int T_RP  = 3,
   parameter int T_CAS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic             oe_n,
   input logic [MUX_W-1:0] addr,
   input logic             dq_oe,
   input logic             ready,
   input logic             rsp_valid
);

   localparam logic [7:0] RP8  = 8'(T_RP);
   localparam logic [7:0] CAS8 = 8'(T_CAS);

   logic [7:0] ras_hi_cnt;
   logic [7:0] cas_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_hi_cnt <= RP8;
         cas_lo_cnt <= '0;
      end else begin
         if (!ras_n)                 ras_hi_cnt <= '0;
         else if (ras_hi_cnt != '1)  ras_hi_cnt <= ras_hi_cnt + 1'b1;
         if (cas_n)                  cas_lo_cnt <= '0;
         else if (cas_lo_cnt != '1)  cas_lo_cnt <= cas_lo_cnt + 1'b1;
      end
   end

   a_r2_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $stable(addr));

   a_r3_col_and_w_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> ($stable(addr) && $stable(we_n)));

   a_r4_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !we_n);

   a_r4_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (we_n && !cas_n));

   a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (ras_hi_cnt >= RP8));

   a_r7_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   a_r9_ready_no_column: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cas_n && we_n && !dq_oe));

   a_r10_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r10_rsp_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!cas_n));

   a_r12_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n) |-> (cas_lo_cnt == CAS8));

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
   .MUX_W (MUX_W),
   .T_RP  (T_RP),
   .T_CAS (T_CAS)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ras_n     (dram_ras_n),
   .cas_n     (dram_cas_n),
   .we_n      (dram_we_n),
   .oe_n      (dram_oe_n),
   .addr      (dram_addr),
   .dq_oe     (dram_dq_oe),
   .ready     (req_ready),
   .rsp_valid (rsp_valid)
);

// File: tb/test_fpm_dram_ctrl.sv
module test_fpm_dram_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int T_RP  = 2;
   localparam int T_RAH = 1;
   localparam int T_CAS = 2;
   localparam int T_CP  = 1;
   localparam int T_REF = 3;
   localparam int REF_INT = 150;
   localparam int WATCHDOG_CYCLES = 20000;

   typedef struct packed {
      logic        we;
      logic [15:0] addr;
      logic [3:0]  wd;
      logic [3:0]  exp;
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{1'b1, 16'h1234, 4'h5, 4'h0},
      '{1'b1, 16'h1235, 4'hA, 4'h0},
      '{1'b0, 16'h1234, 4'h0, 4'h5},
      '{1'b1, 16'h5678, 4'h3, 4'h0},
      '{1'b0, 16'h1235, 4'h0, 4'hA},
      '{1'b0, 16'h5678, 4'h0, 4'h3},
      '{1'b1, 16'h56FF, 4'hF, 4'h0},
      '{1'b0, 16'h56FF, 4'h0, 4'hF},
      '{1'b1, 16'hFFFF, 4'h9, 4'h0},
      '{1'b0, 16'hFFFF, 4'h0, 4'h9},
      '{1'b1, 16'h0000, 4'h6, 4'h0},
      '{1'b0, 16'h0000, 4'h0, 4'h6}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [3:0]  rsp_rdata;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [7:0]  dram_addr;
   logic [3:0]  dram_dq_out, dram_dq_in;

   int compared = 0;
   int mismatched = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpm_dram_ctrl #(
      .T_RP (T_RP), .T_RAH (T_RAH), .T_CAS (T_CAS), .T_CP (T_CP),
      .T_REF (T_REF), .REF_INTERVAL (REF_INT)
   ) i_fpm_dram_ctrl (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n),
      .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
      .dram_addr (dram_addr), .dram_dq_out (dram_dq_out),
      .dram_dq_oe (dram_dq_oe), .dram_dq_in (dram_dq_in)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   // Device model and pin monitor, sampled on the falling clock edge
   logic [3:0] mem [int unsigned];
   logic [3:0] rd_val = '0;
   logic       cur_we = 1'b0;
   logic [15:0] cur_addr = '0;
   logic [3:0] cur_wd = '0;
   logic       prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
   logic [7:0] prev_addr = '0, fall_row = '0, last_ref_row = '0;
   bit         had_cas = 1'b0, have_ref = 1'b0;
   int         act_cnt = 0, ref_cnt = 0, drive_cnt = 0, cas_lo = 0;

   assign dram_dq_in = (!dram_oe_n) ? rd_val : 4'h0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (dram_dq_oe) drive_cnt++;
         if (prev_ras && !dram_ras_n) begin
            had_cas  = 1'b0;
            fall_row = dram_addr;
            check(prev_addr == dram_addr, "R2 row stable at row strobe", dram_addr, prev_addr);
         end
         if (prev_cas && !dram_cas_n) begin
            int unsigned k;
            if (!had_cas) begin
               had_cas = 1'b1;
               act_cnt++;
            end
            k = {16'h0, fall_row, dram_addr};
            check(dram_ras_n == 1'b0, "R7 column strobe inside row strobe", dram_ras_n, 0);
            check({fall_row, dram_addr} == cur_addr, "R1 row/column mux", {fall_row, dram_addr}, cur_addr);
            check(dram_we_n == !cur_we, "R3 write strobe level", dram_we_n, !cur_we);
            if (cur_we) begin
               check(prev_we == 1'b0 && dram_dq_out == cur_wd, "R3 early write setup",
                     {prev_we, dram_dq_out}, {1'b0, cur_wd});
               mem[k] = dram_dq_out;
            end else begin
               rd_val = mem.exists(k) ? mem[k] : 4'h0;
            end
         end
         if (!dram_cas_n) cas_lo++;
         if (!prev_cas && dram_cas_n) begin
            check(cas_lo == T_CAS, "R12 column strobe width", cas_lo, T_CAS);
            cas_lo = 0;
         end
         if (!prev_ras && dram_ras_n && !had_cas) begin
            ref_cnt++;
            if (have_ref)
               check(fall_row == last_ref_row + 8'd1, "R8 refresh row increment", fall_row, last_ref_row + 8'd1);
            have_ref     = 1'b1;
            last_ref_row = fall_row;
         end
      end
      prev_ras  = dram_ras_n;
      prev_cas  = dram_cas_n;
      prev_we   = dram_we_n;
      prev_addr = dram_addr;
   end

   // Bench model of the open row, invalidated by any observed refresh
   bit         model_valid = 1'b0;
   logic [7:0] model_row = '0;
   int         model_ref = 0;

   task automatic do_txn(input logic we, input logic [15:0] addr, input logic [3:0] wd,
                         input logic [3:0] exp, output int acts);
      int a0, d0, nrsp;
      bit exp_act;
      logic [3:0] got;
      cur_we = we; cur_addr = addr; cur_wd = wd;
      req_we = we; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
      while (!req_ready) tick();
      a0 = act_cnt; d0 = drive_cnt;
      if (ref_cnt != model_ref) model_valid = 1'b0;
      exp_act = !(model_valid && model_row == addr[15:8]);
      model_row = addr[15:8]; model_valid = 1'b1; model_ref = ref_cnt;
      tick();
      req_valid = 1'b0;
      nrsp = 0; got = '0;
      forever begin
         if (rsp_valid) begin
            nrsp++;
            got = rsp_rdata;
         end
         if (req_ready) break;
         tick();
      end
      acts = act_cnt - a0;
      if (exp_act) check(acts == 1, "R6 row miss opens row", acts, 1);
      else         check(acts == 0, "R5 page hit keeps row", acts, 0);
      if (we) begin
         check(nrsp == 0, "R10 no response on write", nrsp, 0);
         check(drive_cnt - d0 == 1 + T_CAS, "R4 drive cycles on write", drive_cnt - d0, 1 + T_CAS);
      end else begin
         check(nrsp == 1 && got == exp, "R10 read response", {nrsp[3:0], got}, {4'd1, exp});
         check(drive_cnt == d0, "R4 no drive on read", drive_cnt - d0, 0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG_CYCLES);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int acts, r0;
      tick(); tick(); tick();
      check(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe && !rsp_valid,
            "R11 reset pin state",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, rsp_valid}, 5'b11100);
      rst_n = 1'b1;
      tick();
      check(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);

      for (int i = 0; i < 12; i++) begin
         do_txn(VEC[i].we, VEC[i].addr, VEC[i].wd, VEC[i].exp, acts);
      end

      // R9: refresh while a row is open closes it; the same row must be reopened
      do_txn(1'b1, 16'h1234, 4'h7, 4'h0, acts);
      r0 = ref_cnt;
      for (int i = 0; i < 2 * REF_INT; i++) tick();
      check(ref_cnt > r0, "R9 refresh served while idle", ref_cnt - r0, 1);
      do_txn(1'b0, 16'h1234, 4'h0, 4'h7, acts);
      check(acts == 1, "R9 row reopened after refresh", acts, 1);

      // R8: refresh cadence over an idle stretch
      r0 = ref_cnt;
      for (int i = 0; i < 5 * REF_INT; i++) tick();
      check((ref_cnt - r0) >= 4 && (ref_cnt - r0) <= 6, "R8 refresh rate", ref_cnt - r0, 5);

      // Back-to-back page hits after the idle stretch
      do_txn(1'b1, 16'hAB00, 4'h1, 4'h0, acts);
      do_txn(1'b1, 16'hAB01, 4'h2, 4'h0, acts);
      do_txn(1'b0, 16'hAB00, 4'h0, 4'h1, acts);
      do_txn(1'b0, 16'hAB01, 4'h0, 4'h2, acts);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule